// File: doc/BRIEF.md
# Indexed-Addressing Extension Execution Unit

This unit sits beside a byte-addressed microcontroller core and carries out a small group of extra 16-bit instructions meant for software stacks and indexed data access. It owns three 12-bit pointer registers. It can add a short literal to any of them or subtract one, and it can push a byte literal through the third pointer, which serves as the stack pointer. It also runs a combined stack-adjust-and-return, a call whose low target byte comes from the working register, and two byte moves that take two instruction words and address memory relative to the stack pointer.

The core presents one instruction word at a time with a valid strobe. The unit answers with a `done` pulse in the cycle that finishes the instruction. If it refuses an instruction it pulses `illegal` instead. It reaches a single-byte data memory with synchronous reads, a return stack through push and pop strobes, and the core's program counter through a jump strobe. A configuration input enables the whole extension, and that input is expected to be clear after reset. Words that do not belong to the extension are left alone.

States: `S_IDLE` (accepts a first word), `S_RET` (second cycle of adjust-and-return), `S_CALL` (second cycle of the call), `S_MOVE` (waits for a move's second word). Transitions: IDLE→RET on an adjust-and-return, IDLE→CALL on a call, IDLE→MOVE on either move, and RET, CALL or MOVE→IDLE after one completing cycle (or, in MOVE, after a rejected second word). Every other case stays in IDLE.

Top module: `idx_ext_unit`

## Requirements
- R1: After reset all three pointers read 0, the FSM is in S_IDLE, and `done`, `illegal`, `mem_wr`, `mem_rd`, `rs_push`, `rs_pop` and `jump_en` are low.
- R2: A valid extension word seen while `ext_en` is 0 pulses `illegal` in that cycle, does not pulse `done`, writes nothing and leaves every pointer unchanged.
- R3: Word `1110100s ffkkkkkk` with ff in {00,01,10} adds the zero-extended 6-bit k to pointer ff (s=0) or subtracts it (s=1), wrapping modulo 4096. It pulses `done` in its single cycle.
- R4: With ff=11 the same encoding adjusts pointer 2 in the first cycle. In the second cycle it pulses `rs_pop` and `done` together, and it pulses neither in the first cycle.
- R5: Word `0xEA` followed by an 8-bit k writes k to the address held in pointer 2, decrements pointer 2 by one (modulo 4096) and pulses `done`, all in one cycle.
- R6: Word `0x0014` pulses `rs_push` with `rs_push_addr` = `pc_now`+2 (modulo 2^21) in the first cycle. In the second cycle it pulses `jump_en` and `done`, with `jump_addr` = {`pclat`, `wreg`}.
- R7: First word `11101011 0zzzzzzz` reads memory at pointer 2 + z. A second word `1111 aaaaaaaaaaaa` then writes that byte to the absolute address a and pulses `done` in its own cycle. Any number of idle cycles may come between the two words.
- R8: First word `11101011 1zzzzzzz` reads memory at pointer 2 + z. A second word `1111 xxxxx ddddddd` then writes that byte to pointer 2 + d (d zero-extended). Neither pointer changes.
- R9: A move's second word whose top nibble is not `1111` pulses `illegal`, writes nothing, does not pulse `done` and returns the FSM to S_IDLE.
- R10: A valid word in S_IDLE that is none of the extension encodings causes no `done`, no `illegal` and no memory or stack strobe.
- R11: `done` and `illegal` are never high in the same cycle, and `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_en | input | 1 | Configuration enable for the extension |
| instr_valid | input | 1 | Instruction word valid strobe |
| instr_word | input | 16 | Instruction word |
| wreg | input | 8 | Working register value |
| pc_now | input | 21 | Address of the current instruction |
| pclat | input | 13 | Upper program-counter latch bytes |
| mem_addr | output | 12 | Data memory address |
| mem_rd | output | 1 | Read strobe (data returns next cycle) |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| rs_push | output | 1 | Return-stack push strobe |
| rs_push_addr | output | 21 | Return address to push |
| rs_pop | output | 1 | Return-stack pop strobe (performs return) |
| jump_en | output | 1 | Load program counter strobe |
| jump_addr | output | 21 | Jump target |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Instruction rejected pulse |
| ptr0 | output | 12 | Pointer register 0 |
| ptr1 | output | 12 | Pointer register 1 |
| ptr2 | output | 12 | Pointer register 2 (stack pointer) |

## Verification
The checker tests on every cycle that a rejection touches no pointer and drives no strobe, that `done` and `illegal` exclude each other, that a read and a write never share a cycle, that a pop always comes with `done`, and that a return-stack push is always followed by the jump cycle. Only the bench's scenarios can show correct arithmetic: the wrap modulo 4096, the sum of the stack pointer and an offset, the byte carried between the two words of a move across idle gaps, the pushed return address and the jump target. The bench scenarios also cover the cycle on which each instruction's `done` appears.

// File: rtl/idx_ext_pkg.sv
package idx_ext_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RET,
        S_CALL,
        S_MOVE
    } fsm_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADJ,
        K_ADJRET,
        K_PUSH,
        K_CALL,
        K_MVABS,
        K_MVSTK
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic       sub;
        logic [1:0] sel;
        logic [7:0] lit;
        logic [6:0] off;
    } dec_t;

endpackage

// File: rtl/idx_ext_decode.sv
module idx_ext_decode
    import idx_ext_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);
    always_comb begin
        dec.kind = K_NONE;
        dec.sub  = word[8];
        dec.sel  = word[7:6];
        dec.lit  = {2'b00, word[5:0]};
        dec.off  = word[6:0];
        unique case (word[15:8])
            8'hE8, 8'hE9: dec.kind = (word[7:6] == 2'b11) ? K_ADJRET : K_ADJ;
            8'hEA: begin
                dec.kind = K_PUSH;
                dec.lit  = word[7:0];
            end
            8'hEB: dec.kind = word[7] ? K_MVSTK : K_MVABS;
            default: dec.kind = (word == 16'h0014) ? K_CALL : K_NONE;
        endcase
    end
endmodule

// File: rtl/idx_ext_ptrfile.sv
module idx_ext_ptrfile #(
    parameter int AW   = 12,
    parameter int NPTR = 3,
    localparam int SELW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_val,
    output logic [AW-1:0]   ptr_q [NPTR]
);
    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[i] <= '0;
            else if (wr_en && wr_sel == SELW'(i))
                ptr_q[i] <= wr_val;
        end
    end
endmodule

// File: rtl/idx_ext_unit.sv
module idx_ext_unit
    import idx_ext_pkg::*;
#(
    parameter int AW  = 12,
    parameter int PCW = 21,
    localparam int LATW = PCW - 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            instr_valid,
    input  logic [15:0]     instr_word,
    input  logic [7:0]      wreg,
    input  logic [PCW-1:0]  pc_now,
    input  logic [LATW-1:0] pclat,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    output logic            rs_push,
    output logic [PCW-1:0]  rs_push_addr,
    output logic            rs_pop,
    output logic            jump_en,
    output logic [PCW-1:0]  jump_addr,
    output logic            done,
    output logic            illegal,
    output logic [AW-1:0]   ptr0,
    output logic [AW-1:0]   ptr1,
    output logic [AW-1:0]   ptr2
);
    localparam int NPTR = 3;
    localparam logic [1:0] SP = 2'd2;

    fsm_t       state, nxt;
    dec_t       dec;
    logic       mv_stk_q, mv_stk_d;
    logic       rd_pend_q;
    logic [7:0] hold_q;
    logic       p_we;
    logic [1:0] p_sel;
    logic [AW-1:0] p_val;
    logic [AW-1:0] ptr_q [NPTR];

    idx_ext_decode u_dec (.word(instr_word), .dec(dec));

    idx_ext_ptrfile #(.AW(AW), .NPTR(NPTR)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(p_we), .wr_sel(p_sel),
        .wr_val(p_val), .ptr_q(ptr_q)
    );

    assign ptr0 = ptr_q[0];
    assign ptr1 = ptr_q[1];
    assign ptr2 = ptr_q[2];

    // state register and move context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            mv_stk_q  <= 1'b0;
            rd_pend_q <= 1'b0;
            hold_q    <= '0;
        end else begin
            state     <= nxt;
            mv_stk_q  <= mv_stk_d;
            rd_pend_q <= (state == S_IDLE);
            if (state == S_MOVE && rd_pend_q)
                hold_q <= mem_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        nxt          = state;
        mv_stk_d     = mv_stk_q;
        mem_addr     = '0;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        mem_wdata    = '0;
        rs_push      = 1'b0;
        rs_push_addr = pc_now + PCW'(2);
        rs_pop       = 1'b0;
        jump_en      = 1'b0;
        jump_addr    = {pclat, wreg};
        done         = 1'b0;
        illegal      = 1'b0;
        p_we         = 1'b0;
        p_sel        = dec.sel;
        p_val        = '0;
        unique case (state)
            S_IDLE: begin
                if (instr_valid && dec.kind != K_NONE && !ext_en) begin
                    illegal = 1'b1;
                end else if (instr_valid) begin
                    unique case (dec.kind)
                        K_NONE: ;
                        K_ADJ, K_ADJRET: begin
                            p_we  = 1'b1;
                            p_sel = (dec.kind == K_ADJRET) ? SP : dec.sel;
                            p_val = dec.sub ? ptr_q[p_sel] - AW'(dec.lit)
                                            : ptr_q[p_sel] + AW'(dec.lit);
                            if (dec.kind == K_ADJRET) nxt = S_RET;
                            else                      done = 1'b1;
                        end
                        K_PUSH: begin
                            mem_wr    = 1'b1;
                            mem_addr  = ptr_q[SP];
                            mem_wdata = dec.lit;
                            p_we      = 1'b1;
                            p_sel     = SP;
                            p_val     = ptr_q[SP] - AW'(1);
                            done      = 1'b1;
                        end
                        K_CALL: begin
                            rs_push = 1'b1;
                            nxt     = S_CALL;
                        end
                        K_MVABS, K_MVSTK: begin
                            mem_rd   = 1'b1;
                            mem_addr = ptr_q[SP] + AW'(dec.off);
                            mv_stk_d = (dec.kind == K_MVSTK);
                            nxt      = S_MOVE;
                        end
                        default: ;
                    endcase
                end
            end
            S_RET: begin
                rs_pop = 1'b1;
                done   = 1'b1;
                nxt    = S_IDLE;
            end
            S_CALL: begin
                jump_en = 1'b1;
                done    = 1'b1;
                nxt     = S_IDLE;
            end
            S_MOVE: begin
                if (instr_valid) begin
                    nxt = S_IDLE;
                    if (instr_word[15:12] == 4'hF) begin
                        mem_wr    = 1'b1;
                        mem_addr  = mv_stk_q ? ptr_q[SP] + AW'(instr_word[6:0])
                                             : instr_word[AW-1:0];
                        mem_wdata = rd_pend_q ? mem_rdata : hold_q;
                        done      = 1'b1;
                    end else begin
                        illegal = 1'b1;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/idx_ext_chk.sv
module idx_ext_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          illegal,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          rs_push,
    input logic          rs_pop,
    input logic          jump_en,
    input logic [AW-1:0] ptr0,
    input logic [AW-1:0] ptr1,
    input logic [AW-1:0] ptr2
);
    // R11
    assert_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));
    // R11
    assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R2, R9
    assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_wr && !rs_push && !rs_pop && !jump_en);
    // R2
    assert_illegal_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable({ptr0, ptr1, ptr2}));
    // R4
    assert_pop_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_pop |-> done);
    // R6
    assert_push_then_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rs_push |=> jump_en && done);
    // R6
    assert_push_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rs_push |-> !done);
endmodule

bind idx_ext_unit idx_ext_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .illegal(illegal),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rs_push(rs_push), .rs_pop(rs_pop),
    .jump_en(jump_en), .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2)
);

// File: tb/sim_idx_ext_unit.sv
`timescale 1ns/1ps
module sim_idx_ext_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [7:0]  wreg = '0;
    logic [20:0] pc_now = '0;
    logic [12:0] pclat = '0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        rs_push, rs_pop, jump_en, done, illegal;
    logic [20:0] rs_push_addr, jump_addr;
    logic [11:0] ptr0, ptr1, ptr2;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mem [4096];

    always #2 clk = ~clk;

    idx_ext_unit u0 (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .instr_valid(instr_valid),
        .instr_word(instr_word), .wreg(wreg), .pc_now(pc_now), .pclat(pclat),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rs_push(rs_push),
        .rs_push_addr(rs_push_addr), .rs_pop(rs_pop), .jump_en(jump_en),
        .jump_addr(jump_addr), .done(done), .illegal(illegal),
        .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge and settle
    task automatic step(input logic v, input logic [15:0] w);
        @(negedge clk);
        instr_valid = v;
        instr_word  = w;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 ptr0", ptr0, 0);
        chk("R1 ptr1", ptr1, 0);
        chk("R1 ptr2", ptr2, 0);
        chk("R1 strobes", {done, illegal, mem_wr, mem_rd, rs_push, rs_pop, jump_en}, 0);
    endtask

    task automatic t_disabled();
        ext_en = 1'b0;
        step(1, 16'hE805);
        chk("R2 illegal", illegal, 1);
        chk("R2 no done", done, 0);
        step(1, 16'hEA11);
        chk("R2 illegal push", illegal, 1);
        chk("R2 no write", mem_wr, 0);
        step(0, 16'h0);
        chk("R2 ptr0 kept", ptr0, 0);
        chk("R2 ptr2 kept", ptr2, 0);
        ext_en = 1'b1;
    endtask

    task automatic t_adjust();
        step(1, 16'hE83F);
        chk("R3 add done", done, 1);
        step(1, 16'hE945);
        chk("R3 sub done", done, 1);
        step(1, 16'hE890);
        step(0, 16'h0);
        chk("R3 ptr0 add 63", ptr0, 12'd63);
        chk("R3 ptr1 wrap", ptr1, 12'd4091);
        chk("R3 ptr2 add 16", ptr2, 12'd16);
    endtask

    task automatic t_adjret();
        step(1, 16'hE8C4);
        chk("R4 first cycle no pop", {rs_pop, done}, 0);
        step(0, 16'h0);
        chk("R4 pop and done", {rs_pop, done}, 2'b11);
        chk("R4 ptr2 +4", ptr2, 12'd20);
        step(1, 16'hE9C4);
        step(0, 16'h0);
        chk("R4 sub pop", rs_pop, 1);
        chk("R4 ptr2 -4", ptr2, 12'd16);
    endtask

    task automatic t_push();
        step(1, 16'hEA5A);
        chk("R5 write", {mem_wr, done}, 2'b11);
        chk("R5 addr", mem_addr, 12'd16);
        chk("R5 data", mem_wdata, 8'h5A);
        step(0, 16'h0);
        chk("R5 ptr2 dec", ptr2, 12'd15);
        chk("R5 mem stored", mem[16], 8'h5A);
    endtask

    task automatic t_call();
        wreg   = 8'h34;
        pclat  = 13'h0ABC;
        pc_now = 21'h1FFFFF;
        step(1, 16'h0014);
        chk("R6 push", {rs_push, done, jump_en}, 3'b100);
        chk("R6 return addr wraps", rs_push_addr, 21'h000001);
        step(0, 16'h0);
        chk("R6 jump", {jump_en, done, rs_push}, 3'b110);
        chk("R6 target", jump_addr, {13'h0ABC, 8'h34});
    endtask

    task automatic t_move_abs();
        mem[18] = 8'hC3;
        step(1, 16'hEB03);
        chk("R7 read", mem_rd, 1);
        chk("R7 read addr", mem_addr, 12'd18);
        chk("R7 not done", done, 0);
        step(1, 16'hF123);
        chk("R7 write", {mem_wr, done}, 2'b11);
        chk("R7 dest", mem_addr, 12'h123);
        chk("R7 data", mem_wdata, 8'hC3);
        step(0, 16'h0);
        chk("R7 ptr2 kept", ptr2, 12'd15);
    endtask

    task automatic t_move_stk();
        mem[17] = 8'h77;
        step(1, 16'hEB82);
        chk("R8 read addr", mem_addr, 12'd17);
        step(0, 16'h0);
        step(0, 16'h0);
        mem[17] = 8'h00;
        step(1, 16'hF005);
        chk("R8 write", {mem_wr, done}, 2'b11);
        chk("R8 dest", mem_addr, 12'd20);
        chk("R8 data held", mem_wdata, 8'h77);
        step(0, 16'h0);
        chk("R8 ptr2 kept", ptr2, 12'd15);
    endtask

    task automatic t_bad_second();
        step(1, 16'hEB01);
        step(1, 16'hA123);
        chk("R9 illegal", illegal, 1);
        chk("R9 no write", {mem_wr, done}, 0);
        step(1, 16'hE801);
        chk("R9 back to idle", done, 1);
        step(0, 16'h0);
        chk("R9 ptr0", ptr0, 12'd64);
    endtask

    task automatic t_other();
        step(1, 16'h1234);
        chk("R10 ignored", {done, illegal, mem_wr, mem_rd, rs_push, rs_pop, jump_en}, 0);
        step(1, 16'h0015);
        chk("R10 near call ignored", {done, illegal, rs_push}, 0);
        step(0, 16'h0);
        chk("R10 ptrs kept", {ptr0, ptr1, ptr2}, {12'd64, 12'd4091, 12'd15});
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_disabled();
        t_adjust();
        t_adjret();
        t_push();
        t_call();
        t_move_abs();
        t_move_stk();
        t_bad_second();
        t_other();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule